// File: doc/BRIEF.md
# DRAM Read/Write Turnaround Scheduler

This block is the state machine at the heart of a DRAM controller's command multiplexer. It decides whether the shared data bus is serving reads or writes. It inserts the bus turnaround waits that the PHY latencies require, and it bounds how long one direction may hold the bus while the other has work waiting. It tells the downstream command arbiters which command classes they may pick this cycle. It also tells the per-phase steering logic which arbiter output drives each phase of the DFI command slot.

Two spacing timers keep back-to-back activates at least tRRD cycles apart and back-to-back column commands at least tCCD cycles apart. A refresh request from the refresher takes the scheduler out of data traffic. The scheduler then raises a refresh request to every bank machine and holds the refresh command back until each bank machine has granted it.

Top module: `ddr_turn_sched`

## Requirements
- R1: After reset the scheduler is in the read period. `want_reads`, `want_cmds` and `want_acts` are high, `want_writes` is low and `bank_ref_req` is all zero.
- R2: In the read period the scheduler leaves for writes when `wr_avail` is high and either `rd_avail` is low or the read budget has expired. The write period starts exactly READ_LAT cycles after the last read-period cycle (READ_LAT >= 2). During the wait every want is low and every phase steers idle.
- R3: In the write period the scheduler leaves for reads when `ref_valid` is high, or when `rd_avail` is high and either `wr_avail` is low or the write budget has expired. The read period starts exactly T_WTR + ceil(CWL/N_PHASES) + T_CCD cycles after the last write-period cycle, and the wait is quiet in the same way as in R2.
- R4: With work pending in both directions, a read period lasts READ_BUDGET cycles and a write period lasts WRITE_BUDGET cycles before the switch. Each budget restarts whenever its period is left.
- R5: The read budget is expired straight after reset, so a write that is pending in the first cycle preempts reads at once, even if reads are also pending.
- R6: An accepted activate (`act_accept`) drops `want_acts` for the next T_RRD-1 cycles. It rises again T_RRD cycles after the accept.
- R7: An accepted column command (`col_accept`) drops `want_reads` and `want_writes` for the next T_CCD-1 cycles. They become available again T_CCD cycles after the accept.
- R8: In the read period, `ref_valid` takes precedence over a write switch and enters the refresh state. In that state every bit of `bank_ref_req` is high and all wants are low. `ref_go` is high only while every `bank_gnt` bit is high. `ref_go` with `ref_accept` returns the scheduler to the read period on the next cycle. In the write period, `ref_valid` first causes the normal turnaround to reads.
- R9: `steer_sel` holds one 2-bit code per phase, with phase p at bits [2p+1:2p]. The codes are idle=0, bank command=1, column request=2 and refresh=3. In the read period, RD_PHASE carries 2 and RDCMD_PHASE carries 1. In the write period, WR_PHASE carries 2 and WRCMD_PHASE carries 1. In the refresh state, phase 0 carries 3. All other phases carry 0.
- R10: `want_cmds` is high throughout the read and write periods and low in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_avail | input | 1 | Some bank machine has a read pending |
| wr_avail | input | 1 | Some bank machine has a write pending |
| ref_valid | input | 1 | Refresher requests a refresh |
| bank_gnt | input | N_BANKS | Per-bank refresh grant |
| act_accept | input | 1 | An activate was accepted this cycle |
| col_accept | input | 1 | A read or write command was accepted this cycle |
| ref_accept | input | 1 | The refresh command was accepted this cycle |
| want_reads | output | 1 | Read arbiter may pick read commands |
| want_writes | output | 1 | Write arbiter may pick write commands |
| want_cmds | output | 1 | Command arbiter may pick non-column commands |
| want_acts | output | 1 | Command arbiter may pick activates |
| steer_sel | output | 2*N_PHASES | Per-phase steering code |
| bank_ref_req | output | N_BANKS | Refresh request to each bank machine |
| ref_go | output | 1 | Refresh command may be issued |

## Verification
The bench builds the block with READ_LAT=5, CWL=3, N_PHASES=2, T_WTR=2, T_CCD=3, T_RRD=6, READ_BUDGET=8, WRITE_BUDGET=5 and four banks. With these values the 7-cycle write-to-read wait and the 5-cycle read-to-write wait are clearly different, so a swapped or miscounted turnaround shows up. The short budgets let several complete read/write alternations fit in a short run. The spacing values of 6 and 3 make gaps of more than one cycle visible on `want_acts` and on the column wants. The staggered grants on the four banks show that `ref_go` waits for the last grant.

// File: rtl/ddr_turn_sched_pkg.sv
package ddr_turn_sched_pkg;

    typedef enum logic [2:0] {
        ST_READ    = 3'd0,
        ST_TO_WR   = 3'd1,
        ST_WRITE   = 3'd2,
        ST_TO_RD   = 3'd3,
        ST_REFRESH = 3'd4
    } sched_st_e;

    localparam logic [1:0] STEER_IDLE = 2'd0;
    localparam logic [1:0] STEER_BCMD = 2'd1;
    localparam logic [1:0] STEER_COL  = 2'd2;
    localparam logic [1:0] STEER_REF  = 2'd3;

endpackage

// File: rtl/ddr_gap_timer.sv
// Minimum-spacing timer: busy for GAP-1 cycles after a load pulse.
module ddr_gap_timer #(
    parameter int GAP = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int CW = (GAP > 1) ? $clog2(GAP) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(GAP - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = RELOAD;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/ddr_budget_timer.sv
// Per-direction budget: counts down while its period is active, reloads otherwise.
module ddr_budget_timer #(
    parameter int BUDGET        = 16,
    parameter bit START_EXPIRED = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic expired
);
    localparam int CW = $clog2(BUDGET + 1);
    localparam logic [CW-1:0] RELOAD = CW'(BUDGET - 1);
    localparam logic [CW-1:0] RST_VAL = START_EXPIRED ? '0 : RELOAD;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!active)
            cnt_d = RELOAD;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= RST_VAL;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/ddr_phase_steer.sv
// Per-phase steering code from the scheduler state.
module ddr_phase_steer
    import ddr_turn_sched_pkg::*;
#(
    parameter int N_PHASES    = 2,
    parameter int RD_PHASE    = 0,
    parameter int RDCMD_PHASE = 1,
    parameter int WR_PHASE    = 1,
    parameter int WRCMD_PHASE = 0
) (
    input  sched_st_e             st,
    output logic [2*N_PHASES-1:0] steer_sel
);
    for (genvar p = 0; p < N_PHASES; p++) begin : g_phase
        always_comb begin
            steer_sel[2*p +: 2] = STEER_IDLE;
            unique case (st)
                ST_READ: begin
                    if (p == RD_PHASE)         steer_sel[2*p +: 2] = STEER_COL;
                    else if (p == RDCMD_PHASE) steer_sel[2*p +: 2] = STEER_BCMD;
                end
                ST_WRITE: begin
                    if (p == WR_PHASE)         steer_sel[2*p +: 2] = STEER_COL;
                    else if (p == WRCMD_PHASE) steer_sel[2*p +: 2] = STEER_BCMD;
                end
                ST_REFRESH: begin
                    if (p == 0)                steer_sel[2*p +: 2] = STEER_REF;
                end
                default: steer_sel[2*p +: 2] = STEER_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ddr_turn_sched.sv
module ddr_turn_sched
    import ddr_turn_sched_pkg::*;
#(
    parameter int N_BANKS      = 8,
    parameter int N_PHASES     = 2,
    parameter int READ_LAT     = 5,
    parameter int CWL          = 3,
    parameter int T_WTR        = 2,
    parameter int T_CCD        = 1,
    parameter int T_RRD        = 1,
    parameter int READ_BUDGET  = 32,
    parameter int WRITE_BUDGET = 16,
    parameter int RD_PHASE     = 0,
    parameter int RDCMD_PHASE  = 1,
    parameter int WR_PHASE     = 1,
    parameter int WRCMD_PHASE  = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_avail,
    input  logic                  wr_avail,
    input  logic                  ref_valid,
    input  logic [N_BANKS-1:0]    bank_gnt,
    input  logic                  act_accept,
    input  logic                  col_accept,
    input  logic                  ref_accept,
    output logic                  want_reads,
    output logic                  want_writes,
    output logic                  want_cmds,
    output logic                  want_acts,
    output logic [2*N_PHASES-1:0] steer_sel,
    output logic [N_BANKS-1:0]    bank_ref_req,
    output logic                  ref_go
);
    localparam int WR_LAT   = (CWL + N_PHASES - 1) / N_PHASES;
    localparam int WTR_CYC  = T_WTR + WR_LAT + T_CCD;
    localparam int MAX_TURN = (WTR_CYC > READ_LAT) ? WTR_CYC : READ_LAT;
    localparam int HW       = $clog2(MAX_TURN + 1);
    localparam logic [HW-1:0] RTW_LOAD = HW'(READ_LAT - 2);
    localparam logic [HW-1:0] WTR_LOAD = HW'(WTR_CYC - 2);

    typedef struct packed {
        sched_st_e     st;
        logic [HW-1:0] hold;
    } fsm_t;

    fsm_t fsm_d, fsm_q;
    logic rd_expired, wr_expired, rrd_busy, ccd_busy;
    logic in_read, in_write, in_ref;

    assign in_read  = (fsm_q.st == ST_READ);
    assign in_write = (fsm_q.st == ST_WRITE);
    assign in_ref   = (fsm_q.st == ST_REFRESH);
    assign ref_go   = in_ref && (&bank_gnt);

    ddr_budget_timer #(.BUDGET(READ_BUDGET), .START_EXPIRED(1'b1)) u_rd_budget (
        .clk(clk), .rst_n(rst_n), .active(in_read), .expired(rd_expired)
    );
    ddr_budget_timer #(.BUDGET(WRITE_BUDGET), .START_EXPIRED(1'b0)) u_wr_budget (
        .clk(clk), .rst_n(rst_n), .active(in_write), .expired(wr_expired)
    );
    ddr_gap_timer #(.GAP(T_RRD)) u_rrd (
        .clk(clk), .rst_n(rst_n), .load(act_accept), .busy(rrd_busy)
    );
    ddr_gap_timer #(.GAP(T_CCD)) u_ccd (
        .clk(clk), .rst_n(rst_n), .load(col_accept), .busy(ccd_busy)
    );

    always_comb begin
        fsm_d = fsm_q;
        unique case (fsm_q.st)
            ST_READ: begin
                if (ref_valid) begin
                    fsm_d.st = ST_REFRESH;
                end else if (wr_avail && (!rd_avail || rd_expired)) begin
                    fsm_d.st   = ST_TO_WR;
                    fsm_d.hold = RTW_LOAD;
                end
            end
            ST_TO_WR: begin
                if (fsm_q.hold == '0) fsm_d.st = ST_WRITE;
                else                  fsm_d.hold = fsm_q.hold - 1'b1;
            end
            ST_WRITE: begin
                if (ref_valid || (rd_avail && (!wr_avail || wr_expired))) begin
                    fsm_d.st   = ST_TO_RD;
                    fsm_d.hold = WTR_LOAD;
                end
            end
            ST_TO_RD: begin
                if (fsm_q.hold == '0) fsm_d.st = ST_READ;
                else                  fsm_d.hold = fsm_q.hold - 1'b1;
            end
            ST_REFRESH: begin
                if (ref_go && ref_accept) fsm_d.st = ST_READ;
            end
            default: fsm_d.st = ST_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{st: ST_READ, hold: '0};
        else        fsm_q <= fsm_d;
    end

    assign want_reads   = in_read && !ccd_busy;
    assign want_writes  = in_write && !ccd_busy;
    assign want_cmds    = in_read || in_write;
    assign want_acts    = (in_read || in_write) && !rrd_busy;
    assign bank_ref_req = {N_BANKS{in_ref}};

    ddr_phase_steer #(
        .N_PHASES(N_PHASES), .RD_PHASE(RD_PHASE), .RDCMD_PHASE(RDCMD_PHASE),
        .WR_PHASE(WR_PHASE), .WRCMD_PHASE(WRCMD_PHASE)
    ) u_steer (
        .st(fsm_q.st), .steer_sel(steer_sel)
    );
endmodule

// File: rtl/ddr_turn_sched_chk.sv
module ddr_turn_sched_chk #(
    parameter int N_BANKS  = 8,
    parameter int N_PHASES = 2,
    parameter int T_RRD    = 1,
    parameter int T_CCD    = 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [N_BANKS-1:0]    bank_gnt,
    input logic                  act_accept,
    input logic                  col_accept,
    input logic                  want_reads,
    input logic                  want_writes,
    input logic                  want_cmds,
    input logic                  want_acts,
    input logic [2*N_PHASES-1:0] steer_sel,
    input logic [N_BANKS-1:0]    bank_ref_req,
    input logic                  ref_go
);
    localparam bit RRD_GAP = (T_RRD > 1);
    localparam bit CCD_GAP = (T_CCD > 1);

    a_r8_go_needs_grants: assert property (@(posedge clk) disable iff (!rst_n)
        ref_go |-> (&bank_gnt));

    a_r8_req_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_ref_req == '0) || (&bank_ref_req));

    a_r8_quiet_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        bank_ref_req[0] |-> !(want_reads || want_writes || want_cmds || want_acts));

    a_r9_refresh_steer: assert property (@(posedge clk) disable iff (!rst_n)
        ref_go |-> (steer_sel[1:0] == 2'd3));

    a_r6_rrd_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (RRD_GAP && act_accept) |=> !want_acts);

    a_r7_ccd_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (CCD_GAP && col_accept) |=> !(want_reads || want_writes));

    a_r2_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
        !(want_reads && want_writes));
endmodule

bind ddr_turn_sched ddr_turn_sched_chk #(
    .N_BANKS(N_BANKS), .N_PHASES(N_PHASES), .T_RRD(T_RRD), .T_CCD(T_CCD)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bank_gnt(bank_gnt), .act_accept(act_accept),
    .col_accept(col_accept), .want_reads(want_reads), .want_writes(want_writes),
    .want_cmds(want_cmds), .want_acts(want_acts), .steer_sel(steer_sel),
    .bank_ref_req(bank_ref_req), .ref_go(ref_go)
);

// File: tb/ddr_turn_sched_tb.sv
`timescale 1ns/1ps
module ddr_turn_sched_tb;
    localparam int NB = 4, NPH = 2, RL = 5, CWL = 3, TWTR = 2, TCCD = 3, TRRD = 6;
    localparam int RB = 8, WB = 5;
    localparam int WTR = TWTR + (CWL + NPH - 1) / NPH + TCCD;
    // modes as seen at the ports: 0 read, 1 to-write, 2 write, 3 to-read, 4 refresh
    localparam int M_R = 0, M_TW = 1, M_W = 2, M_TR = 3, M_REF = 4;

    logic clk = 0, rst_n = 0;
    logic rd_avail = 0, wr_avail = 0, ref_valid = 0, act_accept = 0, col_accept = 0, ref_accept = 0;
    logic [NB-1:0] bank_gnt = '0;
    logic want_reads, want_writes, want_cmds, want_acts, ref_go;
    logic [2*NPH-1:0] steer_sel;
    logic [NB-1:0] bank_ref_req;

    always #5 clk = ~clk;

    ddr_turn_sched #(
        .N_BANKS(NB), .N_PHASES(NPH), .READ_LAT(RL), .CWL(CWL), .T_WTR(TWTR),
        .T_CCD(TCCD), .T_RRD(TRRD), .READ_BUDGET(RB), .WRITE_BUDGET(WB),
        .RD_PHASE(0), .RDCMD_PHASE(1), .WR_PHASE(1), .WRCMD_PHASE(0)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .rd_avail(rd_avail), .wr_avail(wr_avail),
        .ref_valid(ref_valid), .bank_gnt(bank_gnt), .act_accept(act_accept),
        .col_accept(col_accept), .ref_accept(ref_accept), .want_reads(want_reads),
        .want_writes(want_writes), .want_cmds(want_cmds), .want_acts(want_acts),
        .steer_sel(steer_sel), .bank_ref_req(bank_ref_req), .ref_go(ref_go)
    );

    int checks = 0, fails = 0, cycles = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_mode = M_R, m_wait = 0, m_rb = 0, m_wb = WB - 1, m_rrd = 0, m_ccd = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = M_R; m_wait = 0; m_rb = 0; m_wb = WB - 1; m_rrd = 0; m_ccd = 0;
        end else begin
            int nm, nw;
            nm = m_mode; nw = m_wait;
            if (m_mode == M_R) begin
                if (ref_valid) nm = M_REF;
                else if (wr_avail && (!rd_avail || m_rb == 0)) begin nm = M_TW; nw = RL - 1; end
            end else if (m_mode == M_W) begin
                if (ref_valid || (rd_avail && (!wr_avail || m_wb == 0))) begin nm = M_TR; nw = WTR - 1; end
            end else if (m_mode == M_TW || m_mode == M_TR) begin
                nw = m_wait - 1;
                if (nw == 0) nm = (m_mode == M_TW) ? M_W : M_R;
            end else if (m_mode == M_REF) begin
                if ((&bank_gnt) && ref_accept) nm = M_R;
            end
            m_rb = (m_mode == M_R) ? ((m_rb > 0) ? m_rb - 1 : 0) : RB - 1;
            m_wb = (m_mode == M_W) ? ((m_wb > 0) ? m_wb - 1 : 0) : WB - 1;
            m_rrd = act_accept ? TRRD - 1 : ((m_rrd > 0) ? m_rrd - 1 : 0);
            m_ccd = col_accept ? TCCD - 1 : ((m_ccd > 0) ? m_ccd - 1 : 0);
            m_mode = nm; m_wait = nw;
        end
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            int e_st;
            bit rw;
            rw = (m_mode == M_R) || (m_mode == M_W);
            e_st = (m_mode == M_R) ? 6 : (m_mode == M_W) ? 9 : (m_mode == M_REF) ? 3 : 0;
            chk(want_reads == (m_mode == M_R && m_ccd == 0), "R7 want_reads", want_reads, (m_mode == M_R && m_ccd == 0));
            chk(want_writes == (m_mode == M_W && m_ccd == 0), "R7 want_writes", want_writes, (m_mode == M_W && m_ccd == 0));
            chk(want_cmds == rw, "R10 want_cmds", want_cmds, rw);
            chk(want_acts == (rw && m_rrd == 0), "R6 want_acts", want_acts, (rw && m_rrd == 0));
            chk(int'(steer_sel) == e_st, "R9 steer_sel", steer_sel, e_st);
            chk(bank_ref_req == {NB{m_mode == M_REF}}, "R8 bank_ref_req", bank_ref_req, (m_mode == M_REF) ? 15 : 0);
            chk(ref_go == (m_mode == M_REF && (&bank_gnt)), "R8 ref_go", ref_go, (m_mode == M_REF && (&bank_gnt)));
        end
    end

    function automatic int obs_mode();
        case (steer_sel)
            4'h6: return M_R;
            4'h9: return M_W;
            4'h3: return M_REF;
            default: return M_TR;
        endcase
    endfunction

    task automatic cyc();
        @(negedge clk); #2;
    endtask

    task automatic wait_mode(input int m);
        for (int i = 0; i < 100 && obs_mode() != m; i++) cyc();
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        bit saw_read;
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc();
        // R1 reset state
        chk(obs_mode() == M_R && want_reads && want_cmds && want_acts && !want_writes && bank_ref_req == 0,
            "R1 reset state", steer_sel, 6);

        // R5 + R2: both pending at start, write wins, enters write after RL cycles
        rd_avail = 1; wr_avail = 1;
        n = 0;
        for (int i = 0; i < 50; i++) begin
            cyc(); n++;
            if (i == 0) chk(obs_mode() != M_R, "R5 immediate preempt", obs_mode(), M_TR);
            if (obs_mode() == M_W) break;
        end
        chk(n == RL, "R2 read-to-write wait", n, RL);

        // R4 write budget
        n = 1;
        for (int i = 0; i < 50; i++) begin cyc(); if (obs_mode() != M_W) break; n++; end
        chk(n == WB, "R4 write budget", n, WB);
        // R3 write-to-read wait: first non-write sample already taken
        n = 1;
        for (int i = 0; i < 50; i++) begin cyc(); n++; if (obs_mode() == M_R) break; end
        chk(n == WTR, "R3 write-to-read wait", n, WTR);
        // R4 read budget
        n = 1;
        for (int i = 0; i < 50; i++) begin cyc(); if (obs_mode() != M_R) break; n++; end
        chk(n == RB, "R4 read budget", n, RB);

        // back to reads only
        wr_avail = 0;
        wait_mode(M_R);
        cyc(); cyc();
        chk(obs_mode() == M_R, "R4 stays in read without writes", obs_mode(), M_R);

        // R6 activate spacing
        act_accept = 1; cyc(); act_accept = 0;
        n = 1;
        for (int i = 0; i < 50 && !want_acts; i++) begin cyc(); n++; end
        chk(n == TRRD, "R6 activate spacing", n, TRRD);

        // R7 column spacing
        col_accept = 1; cyc(); col_accept = 0;
        n = 1;
        for (int i = 0; i < 50 && !want_reads; i++) begin cyc(); n++; end
        chk(n == TCCD, "R7 column spacing", n, TCCD);

        // R8 refresh from read with staggered grants
        ref_valid = 1; wr_avail = 1;
        cyc();
        chk(obs_mode() == M_REF && bank_ref_req == 4'hF && !ref_go, "R8 refresh entry", bank_ref_req, 15);
        for (int b = 0; b < NB; b++) begin
            cyc();
            chk(!ref_go, "R8 no go before all grants", ref_go, 0);
            bank_gnt[b] = 1'b1;
        end
        cyc();
        chk(ref_go, "R8 go after all grants", ref_go, 1);
        ref_accept = 1; cyc();
        ref_valid = 0; ref_accept = 0; bank_gnt = '0;
        chk(obs_mode() == M_R && bank_ref_req == 0, "R8 refresh exit to read", obs_mode(), M_R);

        // R8 refresh while writing goes through the turnaround first
        rd_avail = 0;
        wait_mode(M_W);
        chk(obs_mode() == M_W, "R2 reached write", obs_mode(), M_W);
        ref_valid = 1;
        saw_read = 0;
        n = 0;
        for (int i = 0; i < 50 && obs_mode() != M_REF; i++) begin
            cyc(); n++;
            if (obs_mode() == M_R) saw_read = 1;
        end
        chk(saw_read && n == WTR + 1, "R8 refresh after write turnaround", n, WTR + 1);
        bank_gnt = '1; ref_accept = 1; cyc();
        ref_valid = 0; ref_accept = 0; bank_gnt = '0; wr_avail = 0;
        cyc();
        chk(obs_mode() == M_R, "R10 read period after refresh", obs_mode(), M_R);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule